// File: doc/BRIEF.md
# Single-Precision Float Load/Store Converter

This block sits between the floating-point register file, which holds every value in the 64-bit double format, and memory, where single-precision operands take 32 bits. A load-single sends the 32-bit memory word through the load path, which widens it to a double. A store-single sends a 64-bit register value through the store path, which narrows it to a single. One operation enters per cycle. `in_store` selects the path, and the result leaves one clock later alongside a registered valid.

Both paths sort the operand into one of four classes: zero, normal, infinity/NaN, or unhandled. For an unhandled operand the block produces no converted value. It raises an assist-trap request and drives a zero result, and a software handler finishes the operation. On a load, the unhandled operands are the single denormals. On a store, they are every nonzero value too small to be a normal single, including values that would fit neither format's denormals. A store of a value too large to be a single also traps, because rounding lies outside this block.

Top module: `fpsc_conv`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_trap` and `out_data` are all zero.
- R2: `out_valid` and `out_store` equal the `in_valid` and `in_store` of the previous cycle. `out_trap` is never high when `out_valid` is low.
- R3: Load path, with `in_data[31]` as sign, `[30:23]` as exponent and `[22:0]` as fraction. If the exponent is 1 to 254, the result has the same sign, exponent plus 896 in `[62:52]`, and the fraction in `[51:29]` with `[28:0]` zero.
- R4: Load path: an exponent of 0 with a zero fraction gives a double zero that keeps the sign bit.
- R5: Load path: an exponent of 0 with a nonzero fraction (a single denormal) sets `out_trap`, and `out_data` is all zero.
- R6: Load path: an exponent of 255 gives exponent 2047. The sign is kept and the fraction is copied to `[51:29]`.
- R7: Store path, with `in_data[63]` as sign, `[62:52]` as exponent and `[51:0]` as fraction. If the exponent is 897 to 1150, `out_data[31:0]` gets the same sign, exponent minus 896 in `[30:23]`, and fraction bits `[51:29]` in `[22:0]`. The lower fraction bits are dropped.
- R8: Store path: an exponent of 0 with a zero fraction gives a single zero carrying the input sign, with no trap.
- R9: Store path: a nonzero operand whose exponent is below 897 sets `out_trap` and gives an all-zero result. This covers single denormal magnitudes, magnitudes between single and double denormals, and double denormals.
- R10: Store path: an exponent from 1151 to 2046 sets `out_trap` and gives an all-zero result.
- R11: Store path: an exponent of 2047 gives exponent 255, with the sign kept and fraction bits `[51:29]` copied. If the fraction is nonzero but those 23 bits are all zero, the result fraction is 1, so that a NaN stays a NaN.
- R12: A store result has `out_data[63:32]` zero. A load ignores `in_data[63:32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_store | input | 1 | 1 selects store-single (double to single), 0 selects load-single |
| in_data | input | 64 | Register value for a store; memory word in bits 31:0 for a load |
| out_valid | output | 1 | Registered result valid |
| out_store | output | 1 | Registered copy of the path selector |
| out_data | output | 64 | Double result for a load; single result in bits 31:0 for a store |
| out_trap | output | 1 | Assist-trap request; the result is zero when set |

## Verification
The load path is swept over every exponent value with four fraction shapes (zero, lowest bit only, top bit only, all ones) and both signs. The upper input word is filled with junk, so the zero/denormal split, the 1 and 254 boundaries and fraction placement are all covered. The store path is swept over all 2048 exponent codes with the same four fraction shapes and both signs. This hits both edges of the 897..1150 normal window, the trap on both sides of it, truncation of the low fraction bits, and the NaN whose payload lies only below bit 29. Idle cycles between vectors show whether valid and trap follow the input valid or stick.

// File: rtl/fpsc_pkg.sv
`timescale 1ns/1ps
package fpsc_pkg;
    localparam int SP_W      = 32;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_W      = 64;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;
    localparam int SP_BIAS   = (1 << (SP_EXP_W - 1)) - 1;
    localparam int DP_BIAS   = (1 << (DP_EXP_W - 1)) - 1;
    localparam int BIAS_GAP  = DP_BIAS - SP_BIAS;
    localparam int PAD_W     = DP_FRAC_W - SP_FRAC_W;
    localparam int SP_EXP_MAX = (1 << SP_EXP_W) - 1;
    // double exponent codes that land inside the single normal range
    localparam int ST_EXP_LO = BIAS_GAP + 1;
    localparam int ST_EXP_HI = BIAS_GAP + SP_EXP_MAX - 1;

    typedef struct packed {
        logic                 sign;
        logic [SP_EXP_W-1:0]  exp;
        logic [SP_FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic                 sign;
        logic [DP_EXP_W-1:0]  exp;
        logic [DP_FRAC_W-1:0] frac;
    } dp_t;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORMAL,
        CLS_SPECIAL,
        CLS_ASSIST
    } op_class_e;

    function automatic op_class_e classify_sp(input sp_t v);
        if (v.exp == '0)
            return (v.frac == '0) ? CLS_ZERO : CLS_ASSIST;
        else if (v.exp == '1)
            return CLS_SPECIAL;
        return CLS_NORMAL;
    endfunction

    function automatic op_class_e classify_dp(input dp_t v);
        if (v.exp == '0 && v.frac == '0)
            return CLS_ZERO;
        else if (v.exp == '1)
            return CLS_SPECIAL;
        else if (v.exp >= DP_EXP_W'(ST_EXP_LO) && v.exp <= DP_EXP_W'(ST_EXP_HI))
            return CLS_NORMAL;
        return CLS_ASSIST;
    endfunction
endpackage

// File: rtl/fpsc_load_path.sv
`timescale 1ns/1ps
module fpsc_load_path
    import fpsc_pkg::*;
(
    input  sp_t op,
    output dp_t res,
    output logic trap
);
    op_class_e cls;

    always_comb begin
        cls  = classify_sp(op);
        res  = '0;
        trap = 1'b0;
        unique case (cls)
            CLS_ZERO: res.sign = op.sign;
            CLS_NORMAL: begin
                res.sign = op.sign;
                res.exp  = DP_EXP_W'(op.exp) + DP_EXP_W'(BIAS_GAP);
                res.frac = {op.frac, {PAD_W{1'b0}}};
            end
            CLS_SPECIAL: begin
                res.sign = op.sign;
                res.exp  = '1;
                res.frac = {op.frac, {PAD_W{1'b0}}};
            end
            default: trap = 1'b1;
        endcase
    end
endmodule

// File: rtl/fpsc_store_path.sv
`timescale 1ns/1ps
module fpsc_store_path
    import fpsc_pkg::*;
(
    input  dp_t op,
    output sp_t res,
    output logic trap
);
    op_class_e cls;
    logic [SP_FRAC_W-1:0] hi_frac;

    always_comb begin
        cls     = classify_dp(op);
        hi_frac = op.frac[DP_FRAC_W-1 -: SP_FRAC_W];
        res     = '0;
        trap    = 1'b0;
        unique case (cls)
            CLS_ZERO: res.sign = op.sign;
            CLS_NORMAL: begin
                res.sign = op.sign;
                res.exp  = SP_EXP_W'(op.exp - DP_EXP_W'(BIAS_GAP));
                res.frac = hi_frac;
            end
            CLS_SPECIAL: begin
                res.sign = op.sign;
                res.exp  = '1;
                // keep a NaN a NaN when its payload sat only in dropped bits
                res.frac = (op.frac != '0 && hi_frac == '0)
                         ? SP_FRAC_W'(1) : hi_frac;
            end
            default: trap = 1'b1;
        endcase
    end
endmodule

// File: rtl/fpsc_conv.sv
`timescale 1ns/1ps
module fpsc_conv
    import fpsc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic            in_store,
    input  logic [DP_W-1:0] in_data,
    output logic            out_valid,
    output logic            out_store,
    output logic [DP_W-1:0] out_data,
    output logic            out_trap
);
    dp_t ld_res;
    sp_t st_res;
    logic ld_trap, st_trap;
    logic [DP_W-1:0] sel_data;
    logic sel_trap;

    fpsc_load_path u_ld (
        .op   (sp_t'(in_data[SP_W-1:0])),
        .res  (ld_res),
        .trap (ld_trap)
    );

    fpsc_store_path u_st (
        .op   (dp_t'(in_data)),
        .res  (st_res),
        .trap (st_trap)
    );

    always_comb begin
        if (in_store) begin
            sel_data = {{(DP_W-SP_W){1'b0}}, st_res};
            sel_trap = st_trap;
        end else begin
            sel_data = ld_res;
            sel_trap = ld_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_store <= 1'b0;
            out_data  <= '0;
            out_trap  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_store <= in_store;
            out_trap  <= in_valid & sel_trap;
            if (in_valid)
                out_data <= sel_data;
        end
    end
endmodule

// File: rtl/fpsc_conv_chk.sv
`timescale 1ns/1ps
module fpsc_conv_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_store,
    input logic [63:0] in_data,
    input logic        out_valid,
    input logic        out_store,
    input logic [63:0] out_data,
    input logic        out_trap
);
    a_r2_valid_lat: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_trap));

    a_r2_store_lat: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_store == $past(in_store)));

    a_r5_trap_zero: assert property (@(posedge clk) disable iff (rst)
        out_trap |-> (out_valid && out_data == 64'd0));

    a_r12_store_upper: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_store) |-> (out_data[63:32] == 32'd0));

    a_r6_load_special: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_store && in_data[30:23] == 8'hFF) |=>
        (out_data[62:52] == 11'h7FF && out_data[63] == $past(in_data[31]) && !out_trap));

    a_r8_store_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store && in_data[62:0] == 63'd0) |=>
        (out_data == {32'd0, $past(in_data[63]), 31'd0} && !out_trap));

    a_r9_store_tiny: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_store && in_data[62:52] < 11'd897 && in_data[62:0] != 63'd0) |=>
        out_trap);
endmodule

bind fpsc_conv fpsc_conv_chk u_chk (.*);

// File: tb/sim_fpsc_conv.sv
`timescale 1ns/1ps
module sim_fpsc_conv;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_store;
    logic [63:0] in_data;
    logic        out_valid;
    logic        out_store;
    logic [63:0] out_data;
    logic        out_trap;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsc_conv u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_store(in_store),
        .in_data(in_data), .out_valid(out_valid), .out_store(out_store),
        .out_data(out_data), .out_trap(out_trap)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // one operation in, result sampled one clock later away from the edge
    task automatic apply(input logic st, input logic [63:0] d,
                         input logic [63:0] exp_d, input logic exp_t,
                         input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_store = st;
        in_data  = d;
        @(posedge clk);
        #1;
        n_vec++;
        if (out_valid !== 1'b1 || out_store !== st ||
            out_data !== exp_d || out_trap !== exp_t) begin
            n_bad++;
            $display("FAIL %s in=%h actual v=%b s=%b d=%h t=%b expected v=1 s=%b d=%h t=%b",
                     req, d, out_valid, out_store, out_data, out_trap, st, exp_d, exp_t);
        end
    endtask

    // R2: an idle cycle gives no valid and no trap
    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_store = 1'b1;
        in_data  = 64'h0000_0000_0000_0001;
        @(posedge clk);
        #1;
        n_vec++;
        if (out_valid !== 1'b0 || out_trap !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle actual v=%b t=%b expected v=0 t=0", out_valid, out_trap);
        end
    endtask

    function automatic logic [22:0] sp_frac_pat(input int k);
        case (k)
            0: return 23'd0;
            1: return 23'd1;
            2: return 23'h400000;
            default: return 23'h7FFFFF;
        endcase
    endfunction

    function automatic logic [51:0] dp_frac_pat(input int k);
        case (k)
            0: return 52'd0;
            1: return 52'd1;
            2: return 52'h8_0000_0000_0000;
            default: return 52'hF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b1;
        in_store = 1'b0;
        in_data  = 64'h0000_0000_0040_0000;
        repeat (3) @(posedge clk);
        #1;
        // R1: held in reset even with an input presented
        n_vec++;
        if (out_valid !== 1'b0 || out_trap !== 1'b0 || out_data !== 64'd0) begin
            n_bad++;
            $display("FAIL R1 actual v=%b t=%b d=%h expected v=0 t=0 d=0",
                     out_valid, out_trap, out_data);
        end
        @(negedge clk);
        rst      = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        n_vec++;
        if (out_valid !== 1'b0 || out_trap !== 1'b0 || out_data !== 64'd0) begin
            n_bad++;
            $display("FAIL R1 post-reset actual v=%b t=%b d=%h expected v=0 t=0 d=0",
                     out_valid, out_trap, out_data);
        end

        // load sweep: R3 R4 R5 R6, upper word junk for R12
        for (int sg = 0; sg < 2; sg++) begin
            for (int e = 0; e < 256; e++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [22:0] f;
                    logic [31:0] w;
                    logic [63:0] xd;
                    logic        xt;
                    int          de;
                    string       req;
                    f  = sp_frac_pat(k);
                    w  = {sg[0], e[7:0], f};
                    de = e + 1023 - 127;
                    xt = 1'b0;
                    if (e == 0 && f == 0) begin
                        xd = {sg[0], 63'd0}; req = "R4";
                    end else if (e == 0) begin
                        xd = 64'd0; xt = 1'b1; req = "R5";
                    end else if (e == 255) begin
                        xd = {sg[0], 11'h7FF, f, 29'd0}; req = "R6";
                    end else begin
                        xd = {sg[0], de[10:0], f, 29'd0}; req = "R3";
                    end
                    apply(1'b0, {32'hA5C3_3C5A ^ 32'(e), w}, xd, xt, {req, "/R12"});
                end
                if (e % 32 == 0) idle();
            end
        end

        // store sweep over every exponent code: R7 R8 R9 R10 R11 R12
        for (int sg = 0; sg < 2; sg++) begin
            for (int e = 0; e < 2048; e++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [51:0] f;
                    logic [22:0] hf;
                    logic [63:0] xd;
                    logic        xt;
                    int          se;
                    string       req;
                    f  = dp_frac_pat(k);
                    hf = f[51:29];
                    se = e - (1023 - 127);
                    xt = 1'b0;
                    if (e == 0 && f == 0) begin
                        xd = {32'd0, sg[0], 31'd0}; req = "R8";
                    end else if (e == 2047) begin
                        if (f != 0 && hf == 0) hf = 23'd1;
                        xd = {32'd0, sg[0], 8'hFF, hf}; req = "R11";
                    end else if (e < 897) begin
                        xd = 64'd0; xt = 1'b1; req = "R9";
                    end else if (e > 1150) begin
                        xd = 64'd0; xt = 1'b1; req = "R10";
                    end else begin
                        xd = {32'd0, sg[0], se[7:0], hf}; req = "R7";
                    end
                    apply(1'b1, {sg[0], e[10:0], f}, xd, xt, req);
                end
                if (e % 256 == 0) idle();
            end
        end

        idle();
        finish_run();
    end
endmodule